// File: doc/BRIEF.md
# UART Line Status and Receive Error Tracker

This block holds the line status word of a UART that can run in either of two modes. In the single-buffer mode, one received character is held at a time. In the queued mode, received characters pass through a receive FIFO of `DEPTH` entries. Each stored entry carries the character together with three error markers: parity wrong, stop bit missing, and line silent for a whole character time. The status word shows the markers of the entry at the head of the queue. A separate summary bit stays set while any queued entry is marked.

On the transmit side the block counts the characters waiting to be sent. In the single-buffer mode one character can wait; in the queued mode `DEPTH` can wait. It also tracks whether the shift register is busy. From these it derives the two transmit-empty status bits and a transmit-empty interrupt request.

A CPU read of the status word has clear-on-read side effects. Toggling the mode input empties the receive side and clears all of its error state.

Top module: `uart_line_status`

## Requirements
- R1: `line_status[0]` is 1 exactly while at least one received character is stored. `rx_pop` removes the head character, and `rx_head` shows the head character while bit 0 is 1.
- R2: In single-buffer mode (`fifo_mode`=0), a character that arrives while one is held replaces it and sets the overrun bit, `line_status[1]`. A character arriving in the same cycle as `rx_pop` of the held one is stored without overrun.
- R3: In queued mode (`fifo_mode`=1), a character that arrives while `DEPTH` entries are stored is discarded and sets `line_status[1]`. The queue order is kept. An arrival in the same cycle as a pop of a full queue is stored without overrun.
- R4: A `stat_read` clears bits 1 (overrun), 2 (parity), 3 (stop bit) and 4 (silent line). An event that sets one of these bits in the same cycle as the read leaves it set.
- R5: Bits 2, 3 and 4 take the `rx_par_err`, `rx_stop_err` and `rx_silent` markers of an entry when that entry becomes the head. The markers accumulate until a read clears them. Markers of entries that are not yet at the head do not show. After a clearing read they stay 0 until a new entry becomes the head.
- R6: In queued mode, `line_status[7]` is 1 whenever a stored entry carries any marker. Once set, it falls only at a `stat_read` at which no marked entry remains.
- R7: In single-buffer mode, `line_status[7]` is 0.
- R8: `line_status[5]` is 1 when no transmit character waits. `tx_write` adds a waiting character (up to 1 in single-buffer mode, `DEPTH` in queued mode; further writes are ignored). `tx_load` moves one waiting character into the shift register.
- R9: `line_status[6]` is 1 only when no transmit character waits and the shift register is idle. A `tx_load` marks the shift register busy and `tx_done` marks it idle.
- R10: `tx_irq` sets when the waiting-character count falls to zero while `tx_irq_en` is 1. It clears on `tx_write` or when `tx_irq_en` is 0.
- R11: A change of `fifo_mode` empties the receive store and clears bits 0 to 4 and 7 in the following cycle. Receive inputs in that cycle are ignored.
- R12: After reset, `line_status` is 8'h60 and `tx_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 0 single-buffer, 1 queued |
| rx_valid | input | 1 | A received character is presented |
| rx_char | input | DW | Received character |
| rx_par_err | input | 1 | Parity marker of the character |
| rx_stop_err | input | 1 | Missing stop bit marker |
| rx_silent | input | 1 | Silent line marker |
| rx_pop | input | 1 | CPU takes the head character |
| stat_read | input | 1 | CPU reads the status word |
| tx_write | input | 1 | CPU writes a transmit character |
| tx_load | input | 1 | Shifter takes a waiting character |
| tx_done | input | 1 | Shifter finished its character |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| rx_head | output | DW | Character at the receive head |
| line_status | output | 8 | Status word |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The properties check these relations on every cycle:
- the summary error bit is 0 in single-buffer mode, and is 1 whenever the marked-entry count is non-zero;
- the marked-entry count never exceeds the stored count;
- an overrun event shows in the next cycle, and a read without a new overrun clears it;
- transmitter empty implies holding empty;
- the interrupt rises only with holding empty and the enable set;
- a mode change leaves the receive bits clear.

The scenarios are needed for orderings:
- head markers appearing only when their entry reaches the head;
- the summary bit outliving the last marked entry until a read;
- the ordering of a full queue around a discarded arrival;
- single-buffer replacement, and the rejected extra transmit write.

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_par_err,
  input  logic          rx_stop_err,
  input  logic          rx_silent,
  input  logic          rx_pop,
  input  logic          stat_read,
  input  logic          tx_write,
  input  logic          tx_load,
  input  logic          tx_done,
  input  logic          tx_irq_en,
  output logic [DW-1:0] rx_head,
  output logic [7:0]    line_status,
  output logic          tx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 3;

  logic          mode_q;
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] rcnt, ecnt, ecnt_n, tcnt, tcnt_n;
  logic          ovr, perr, serr, sil, agg, busy;

  wire          mode_chg = fifo_mode != mode_q;
  wire [CW-1:0] cap      = mode_q ? CW'(DEPTH) : CW'(1);
  wire          rx_empty = rcnt == '0;
  wire          pop      = rx_pop && !rx_empty && !mode_chg;
  wire          in_v     = rx_valid && !mode_chg;
  wire          full     = rcnt == cap;
  wire          push     = in_v && (!full || pop);
  wire          over     = in_v && full && !pop;
  wire          ovwr     = over && !mode_q;

  wire [2:0]    in_err   = {rx_par_err, rx_stop_err, rx_silent};
  wire [EW-1:0] in_ent   = {in_err, rx_char};
  wire [EW-1:0] head     = mem[rp];
  wire [AW-1:0] rp_nx    = rp + 1'b1;
  wire [EW-1:0] nxt_ent  = mem[rp_nx];
  wire          head_err = |head[EW-1:DW];

  wire          arr_push = (push && (rx_empty || (pop && rcnt == CW'(1)))) || ovwr;
  wire          arr_pop  = pop && rcnt > CW'(1);
  wire [2:0]    arr_err  = arr_push ? in_err : (arr_pop ? nxt_ent[EW-1:DW] : 3'b000);

  always_comb begin
    ecnt_n = ecnt + CW'(push && mode_q && |in_err) - CW'(pop && mode_q && head_err);
  end

  always_ff @(posedge clk) begin
    if (ovwr)      mem[rp] <= in_ent;
    else if (push) mem[wp] <= in_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      wp     <= '0;
      rp     <= '0;
      rcnt   <= '0;
      ecnt   <= '0;
      ovr    <= 1'b0;
      perr   <= 1'b0;
      serr   <= 1'b0;
      sil    <= 1'b0;
      agg    <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= fifo_mode;
      wp     <= '0;
      rp     <= '0;
      rcnt   <= '0;
      ecnt   <= '0;
      ovr    <= 1'b0;
      perr   <= 1'b0;
      serr   <= 1'b0;
      sil    <= 1'b0;
      agg    <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp_nx;
      rcnt <= rcnt + CW'(push) - CW'(pop);
      ecnt <= ecnt_n;
      ovr  <= over       | (ovr  & !stat_read);
      perr <= arr_err[2] | (perr & !stat_read);
      serr <= arr_err[1] | (serr & !stat_read);
      sil  <= arr_err[0] | (sil  & !stat_read);
      agg  <= mode_q && (ecnt_n != '0 || (agg && !stat_read));
    end
  end

  wire tw = tx_write && tcnt != cap;
  wire tl = tx_load && tcnt != '0;

  always_comb tcnt_n = tcnt + CW'(tw) - CW'(tl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt   <= '0;
      busy   <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      tcnt <= tcnt_n;
      busy <= tl | (busy & !tx_done);
      if (tx_write || !tx_irq_en)                tx_irq <= 1'b0;
      else if (tcnt != '0 && tcnt_n == '0)       tx_irq <= 1'b1;
    end
  end

  wire thre = tcnt == '0;

  assign rx_head     = head[DW-1:0];
  assign line_status = {agg, thre && !busy, thre, sil, serr, perr, ovr, !rx_empty};
endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic          mode_q,
  input logic          rx_valid,
  input logic          stat_read,
  input logic          tx_irq_en,
  input logic          over,
  input logic [CW-1:0] rcnt,
  input logic [CW-1:0] ecnt,
  input logic [7:0]    line_status,
  input logic          tx_irq
);
  assert_ready_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_status[0]) |-> $past(rx_valid));

  assert_overrun_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> line_status[1]);

  assert_overrun_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && !over) |=> !line_status[1]);

  assert_err_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= rcnt);

  assert_summary_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && ecnt != '0) |-> line_status[7]);

  assert_single_no_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !line_status[7]);

  assert_temt_implies_thre_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[6] |-> line_status[5]);

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> (line_status[5] && $past(tx_irq_en)));

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode != mode_q) |=> (line_status[4:0] == 5'b0 && !line_status[7]));
endmodule

bind uart_line_status uart_line_status_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .mode_q(mode_q),
  .rx_valid(rx_valid), .stat_read(stat_read), .tx_irq_en(tx_irq_en),
  .over(over), .rcnt(rcnt), .ecnt(ecnt), .line_status(line_status),
  .tx_irq(tx_irq)
);

// File: tb/uart_line_status_bench.sv
module uart_line_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0, rx_valid = 1'b0, rx_par_err = 1'b0, rx_stop_err = 1'b0, rx_silent = 1'b0;
  logic rx_pop = 1'b0, stat_read = 1'b0, tx_write = 1'b0, tx_load = 1'b0, tx_done = 1'b0, tx_irq_en = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic [7:0] rx_head, line_status;
  logic tx_irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_line_status u_uart_line_status (.*);

  // m v data err{par,stop,sil} pop rd tw tl td en | status head irq
  localparam int NV = 23;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0,1'b1,8'hA5,3'b000,6'b000000,8'h61,8'hA5,1'b0},
    {1'b0,1'b1,8'h3C,3'b100,6'b000000,8'h67,8'h3C,1'b0},
    {1'b0,1'b0,8'h00,3'b000,6'b010000,8'h61,8'h3C,1'b0},
    {1'b0,1'b0,8'h00,3'b000,6'b100000,8'h60,8'h00,1'b0},
    {1'b0,1'b1,8'h11,3'b001,6'b010000,8'h71,8'h11,1'b0},
    {1'b0,1'b0,8'h00,3'b000,6'b110000,8'h60,8'h00,1'b0},
    {1'b0,1'b0,8'h00,3'b000,6'b001001,8'h00,8'h00,1'b0},
    {1'b0,1'b0,8'h00,3'b000,6'b000101,8'h20,8'h00,1'b1},
    {1'b0,1'b0,8'h00,3'b000,6'b000011,8'h60,8'h00,1'b1},
    {1'b0,1'b0,8'h00,3'b000,6'b001001,8'h00,8'h00,1'b0},
    {1'b0,1'b0,8'h00,3'b000,6'b001001,8'h00,8'h00,1'b0},
    {1'b0,1'b0,8'h00,3'b000,6'b000101,8'h20,8'h00,1'b1},
    {1'b0,1'b0,8'h00,3'b000,6'b000010,8'h60,8'h00,1'b0},
    {1'b1,1'b0,8'h00,3'b000,6'b000000,8'h60,8'h00,1'b0},
    {1'b1,1'b1,8'h01,3'b100,6'b000000,8'hE5,8'h01,1'b0},
    {1'b1,1'b1,8'h02,3'b000,6'b000000,8'hE5,8'h01,1'b0},
    {1'b1,1'b0,8'h00,3'b000,6'b010000,8'hE1,8'h01,1'b0},
    {1'b1,1'b0,8'h00,3'b000,6'b100000,8'hE1,8'h02,1'b0},
    {1'b1,1'b0,8'h00,3'b000,6'b010000,8'h61,8'h02,1'b0},
    {1'b1,1'b1,8'h03,3'b010,6'b000000,8'hE1,8'h02,1'b0},
    {1'b1,1'b0,8'h00,3'b000,6'b100000,8'hE9,8'h03,1'b0},
    {1'b1,1'b0,8'h00,3'b000,6'b100000,8'hE8,8'h00,1'b0},
    {1'b1,1'b0,8'h00,3'b000,6'b010000,8'h60,8'h00,1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic [2:0] e,
                     input logic pp, input logic rd, input logic tw, input logic tl, input logic td);
    rx_valid = v; rx_char = d; {rx_par_err, rx_stop_err, rx_silent} = e;
    rx_pop = pp; stat_read = rd; tx_write = tw; tx_load = tl; tx_done = td;
    @(posedge clk); #2;
    rx_valid = 0; rx_char = 0; {rx_par_err, rx_stop_err, rx_silent} = 3'b000;
    rx_pop = 0; stat_read = 0; tx_write = 0; tx_load = 0; tx_done = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R12 reset status", line_status, 8'h60);
    chk("R12 reset irq", {7'b0, tx_irq}, 8'h00);

    // Table walk: R1 R2 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic m, v, pp, rd, tw, tl, td, en, iq;
      logic [7:0] d, ls, hd;
      logic [2:0] e;
      {m, v, d, e, pp, rd, tw, tl, td, en, ls, hd, iq} = VEC[i];
      fifo_mode = m; tx_irq_en = en;
      cyc(v, d, e, pp, rd, tw, tl, td);
      chk($sformatf("R1/R2/R4/R5/R6/R8/R9 status vec %0d", i), line_status, ls);
      if (ls[0]) chk($sformatf("R1 head vec %0d", i), rx_head, hd);
      chk($sformatf("R10 irq vec %0d", i), {7'b0, tx_irq}, {7'b0, iq});
    end

    // R3: full queue, discarded arrival, order kept
    tx_irq_en = 0;
    for (int i = 0; i < 16; i++) cyc(1, 8'h10 + 8'(i), 3'b000, 0, 0, 0, 0, 0);
    chk("R3 full status", line_status, 8'h61);
    cyc(1, 8'hEE, 3'b000, 0, 1, 0, 0, 0);
    chk("R3 R4 overrun beats read", line_status, 8'h63);
    chk("R3 head kept", rx_head, 8'h10);
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0, 0);
    chk("R4 overrun cleared", line_status, 8'h61);
    cyc(1, 8'hDD, 3'b000, 1, 0, 0, 0, 0);
    chk("R3 push with pop no overrun", line_status, 8'h61);
    for (int i = 0; i < 15; i++) begin
      chk("R3 order", rx_head, 8'h11 + 8'(i));
      cyc(0, 8'h00, 3'b000, 1, 0, 0, 0, 0);
    end
    chk("R3 last entry", rx_head, 8'hDD);
    cyc(0, 8'h00, 3'b000, 1, 0, 0, 0, 0);
    chk("R1 empty after drain", line_status, 8'h60);

    // R11: mode change flushes receive side
    cyc(1, 8'h42, 3'b100, 0, 0, 0, 0, 0);
    chk("R6 marked entry", line_status, 8'hE5);
    fifo_mode = 0;
    cyc(0, 8'h00, 3'b000, 0, 0, 0, 0, 0);
    chk("R11 flush", line_status, 8'h60);

    // R7: single-buffer mode never shows summary bit
    cyc(1, 8'h77, 3'b100, 0, 0, 0, 0, 0);
    chk("R7 no summary", line_status, 8'h65);
    chk("R7 head", rx_head, 8'h77);
    cyc(0, 8'h00, 3'b000, 1, 1, 0, 0, 0);
    chk("R4 pop and read", line_status, 8'h60);

    // R8 R9 R10: queued transmit
    fifo_mode = 1;
    cyc(0, 8'h00, 3'b000, 0, 0, 0, 0, 0);
    chk("R11 flush to queued", line_status, 8'h60);
    tx_irq_en = 1;
    cyc(0, 8'h00, 3'b000, 0, 0, 1, 0, 0);
    chk("R8 write clears empty", line_status, 8'h00);
    cyc(0, 8'h00, 3'b000, 0, 0, 1, 0, 0);
    cyc(0, 8'h00, 3'b000, 0, 0, 1, 0, 0);
    cyc(0, 8'h00, 3'b000, 0, 0, 0, 1, 0);
    chk("R8 two waiting", line_status, 8'h00);
    cyc(0, 8'h00, 3'b000, 0, 0, 0, 1, 0);
    chk("R10 no irq yet", {7'b0, tx_irq}, 8'h00);
    cyc(0, 8'h00, 3'b000, 0, 0, 0, 1, 0);
    chk("R8 R9 holding empty shifter busy", line_status, 8'h20);
    chk("R10 irq on empty", {7'b0, tx_irq}, 8'h01);
    cyc(0, 8'h00, 3'b000, 0, 0, 0, 0, 1);
    chk("R9 all empty", line_status, 8'h60);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule